// File: doc/BRIEF.md
# Shared-Bus Register Transfer Unit

This block holds three data registers that exchange values over one common transfer path. It does not give each register its own source multiplexer. In any cycle one source places a value on the path, and any number of registers capture that value on the next rising clock edge. A move from one register to another takes one cycle: assert the source's drive enable and the destination's load strobe together. A fourth source, the host port, lets outside logic put a value on the path so that data can enter the registers.

The path contains no internal tri-states. It is a priority multiplexer. When no source is enabled, a keeper register presents the last value that was driven. If more than one drive enable is high in the same cycle, the block raises a contention flag and still resolves the path to a single, well-defined source. The stored value of every register can be read on its own observation port.

Top module: `xbus_transfer_unit`

## Requirements
- R1: When exactly one drive enable is high, `bus_o` equals that source's value in the same cycle: register k's stored value for `drv_k_i`, or `host_data_i` for `host_en_i`.
- R2: Every register whose load strobe is high at a rising clock edge takes the value `bus_o` had before that edge, so one source can feed several destinations in one cycle.
- R3: A register whose load strobe is low at a rising edge keeps its stored value.
- R4: A synchronous active-high `rst_i` clears all three registers and the keeper to zero at the next rising edge. After a reset with nothing driven, `bus_o` reads zero.
- R5: When no drive enable is high, `bus_o` shows the value of the most recent cycle in which some source drove the path. A load strobe in such a cycle captures that held value.
- R6: `clash_o` is high in exactly the cycles in which two or more of the four drive enables are high. The path then takes its value from the highest-priority enabled source, in the order register 0, register 1, register 2, host.
- R7: A register whose drive enable and load strobe are both high, and which wins the path, keeps its value unchanged.
- R8: `obs0_o`, `obs1_o` and `obs2_o` show the stored value of registers 0, 1 and 2 at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Rising-edge clock |
| rst_i | input | 1 | Synchronous reset, active high |
| drv_0_i | input | 1 | Register 0 drives the path |
| drv_1_i | input | 1 | Register 1 drives the path |
| drv_2_i | input | 1 | Register 2 drives the path |
| host_en_i | input | 1 | Host port drives the path |
| host_data_i | input | DW | Value driven by the host port |
| ld_0_i | input | 1 | Register 0 captures the path |
| ld_1_i | input | 1 | Register 1 captures the path |
| ld_2_i | input | 1 | Register 2 captures the path |
| bus_o | output | DW | Current value on the shared path |
| clash_o | output | 1 | Two or more drive enables are high |
| obs0_o | output | DW | Stored value of register 0 |
| obs1_o | output | DW | Stored value of register 1 |
| obs2_o | output | DW | Stored value of register 2 |

## Verification
The stimulus mixes four kinds of cycle. Idle cycles, with nothing driven, show whether the keeper holds the last driven value or loses it. Single-driver cycles show whether the path routes the correct source. Cycles with several random enables separate correct priority resolution, and the contention flag, from a design that merges or swaps sources. Host-only cycles bring fresh data into the registers. Directed cases then cover a broadcast load into all three registers, a register that drives and loads itself, loading from an idle path, and a reset in the middle of the run with its cleared keeper.

// File: rtl/xbus_pkg.sv
package xbus_pkg;
    // Number of storage registers that sit on the shared path
    localparam int unsigned XB_NREG = 3;
    // Sources that may drive the path: every register plus the host port
    localparam int unsigned XB_NSRC = XB_NREG + 1;
    // Index of the host port within the priority order (lowest priority)
    localparam int unsigned XB_HOST = XB_NREG;
endpackage

// File: rtl/xbus_cell.sv
module xbus_cell #(
    parameter int unsigned DW = 8
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic          ld_i,
    input  logic [DW-1:0] bus_i,
    output logic [DW-1:0] val_o
);
    typedef struct packed {
        logic [DW-1:0] val;
    } cell_t;

    cell_t c_d, c_q;

    always_comb begin
        c_d = c_q;
        if (rst_i) begin
            c_d.val = '0;
        end else if (ld_i) begin
            c_d.val = bus_i;
        end
    end

    always_ff @(posedge clk_i) begin
        c_q <= c_d;
    end

    assign val_o = c_q.val;

    // R2: a load takes the value of the path from the cycle before
    a_r2_load_captures: assert property (@(posedge clk_i) disable iff (rst_i)
        ld_i |=> val_o == $past(bus_i));
    // R3: without a load the stored value does not move
    a_r3_hold_unloaded: assert property (@(posedge clk_i) disable iff (rst_i)
        !ld_i |=> $stable(val_o));
    // R4: reset clears the register
    a_r4_reset_clears: assert property (@(posedge clk_i)
        rst_i |=> val_o == '0);
endmodule

// File: rtl/xbus_arbiter.sv
module xbus_arbiter #(
    parameter int unsigned NSRC = 4
) (
    input  logic [NSRC-1:0] req_i,
    output logic [NSRC-1:0] grant_o,
    output logic            clash_o
);
    typedef struct packed {
        logic [NSRC-1:0] grant;
        logic            seen;
        logic            clash;
    } arb_t;

    arb_t a_d;

    always_comb begin
        a_d = '0;
        for (int i = 0; i < int'(NSRC); i++) begin
            if (req_i[i]) begin
                if (a_d.seen) begin
                    a_d.clash = 1'b1;
                end else begin
                    a_d.grant[i] = 1'b1;
                    a_d.seen     = 1'b1;
                end
            end
        end
    end

    assign grant_o = a_d.grant;
    assign clash_o = a_d.clash;

    // R6: at most one source is granted and a grant only goes to a requester
    always_comb begin
        a_r6_grant_onehot: assert ($onehot0(grant_o));
        a_r6_grant_requested: assert ((grant_o & ~req_i) == '0);
        // R6: any request yields a grant, and no lower-index source was skipped
        a_r6_lowest_wins: assert ((req_i == '0) ||
            ((grant_o != '0) && (((grant_o - 1'b1) & req_i) == '0)));
        // R6: a clash means the grant no longer covers every request
        a_r6_clash_leftover: assert (!clash_o || (grant_o != req_i));
    end
endmodule

// File: rtl/xbus_keeper.sv
module xbus_keeper #(
    parameter int unsigned DW = 8
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic          drv_i,
    input  logic [DW-1:0] bus_i,
    output logic [DW-1:0] hold_o
);
    typedef struct packed {
        logic [DW-1:0] hold;
    } keep_t;

    keep_t k_d, k_q;

    always_comb begin
        k_d = k_q;
        if (rst_i) begin
            k_d.hold = '0;
        end else if (drv_i) begin
            k_d.hold = bus_i;
        end
    end

    always_ff @(posedge clk_i) begin
        k_q <= k_d;
    end

    assign hold_o = k_q.hold;

    // R5: a driven cycle leaves its value in the keeper
    a_r5_keeper_tracks: assert property (@(posedge clk_i) disable iff (rst_i)
        drv_i |=> hold_o == $past(bus_i));
    // R5: an idle cycle leaves the keeper untouched
    a_r5_keeper_idle: assert property (@(posedge clk_i) disable iff (rst_i)
        !drv_i |=> $stable(hold_o));
    // R4: reset clears the keeper
    a_r4_keeper_reset: assert property (@(posedge clk_i)
        rst_i |=> hold_o == '0);
endmodule

// File: rtl/xbus_transfer_unit.sv
module xbus_transfer_unit
    import xbus_pkg::*;
#(
    parameter int unsigned DW = 8
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic          drv_0_i,
    input  logic          drv_1_i,
    input  logic          drv_2_i,
    input  logic          host_en_i,
    input  logic [DW-1:0] host_data_i,
    input  logic          ld_0_i,
    input  logic          ld_1_i,
    input  logic          ld_2_i,
    output logic [DW-1:0] bus_o,
    output logic          clash_o,
    output logic [DW-1:0] obs0_o,
    output logic [DW-1:0] obs1_o,
    output logic [DW-1:0] obs2_o
);
    logic [XB_NSRC-1:0] req;
    logic [XB_NSRC-1:0] grant;
    logic [XB_NREG-1:0] ld;
    logic [DW-1:0]      src_val [XB_NSRC];
    logic [DW-1:0]      hold;
    logic               any_drv;
    logic [DW-1:0]      bus_d;

    assign req = {host_en_i, drv_2_i, drv_1_i, drv_0_i};
    assign ld  = {ld_2_i, ld_1_i, ld_0_i};

    xbus_arbiter #(.NSRC(XB_NSRC)) arb_i (
        .req_i   (req),
        .grant_o (grant),
        .clash_o (clash_o)
    );

    // Storage registers: state on the clock, drive chosen separately below
    for (genvar g = 0; g < XB_NREG; g++) begin : g_cell
        xbus_cell #(.DW(DW)) cell_i (
            .clk_i (clk_i),
            .rst_i (rst_i),
            .ld_i  (ld[g]),
            .bus_i (bus_o),
            .val_o (src_val[g])
        );
    end

    assign src_val[XB_HOST] = host_data_i;

    assign any_drv = |grant;

    xbus_keeper #(.DW(DW)) keep_i (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .drv_i  (any_drv),
        .bus_i  (bus_o),
        .hold_o (hold)
    );

    // Path mux: the granted source wins, otherwise the keeper holds the path
    always_comb begin
        bus_d = hold;
        for (int i = 0; i < int'(XB_NSRC); i++) begin
            if (grant[i]) begin
                bus_d = src_val[i];
            end
        end
    end

    assign bus_o  = bus_d;
    assign obs0_o = src_val[0];
    assign obs1_o = src_val[1];
    assign obs2_o = src_val[2];

    // R5: an idle path shows exactly what the keeper holds
    a_r5_idle_path: assert property (@(posedge clk_i) disable iff (rst_i)
        (req == '0) |-> bus_o == hold);
    // R1: register 0 alone on the path puts its value there
    a_r1_reg0_drives: assert property (@(posedge clk_i) disable iff (rst_i)
        drv_0_i |-> bus_o == obs0_o);
    // R7: register 0 driving and loading itself keeps its value
    a_r7_self_reload: assert property (@(posedge clk_i) disable iff (rst_i)
        (drv_0_i && ld_0_i) |=> $stable(obs0_o));
endmodule

// File: tb/xbus_transfer_unit_tb.sv
module xbus_transfer_unit_tb_top;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst;
    logic          drv0, drv1, drv2, hen;
    logic [DW-1:0] hdata;
    logic          ld0, ld1, ld2;
    logic [DW-1:0] bus, o0, o1, o2;
    logic          clash;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    logic [DW-1:0] m_reg [3];
    logic [DW-1:0] m_keep;

    always #10 clk = ~clk;

    xbus_transfer_unit #(.DW(DW)) dut_i (
        .clk_i(clk), .rst_i(rst),
        .drv_0_i(drv0), .drv_1_i(drv1), .drv_2_i(drv2),
        .host_en_i(hen), .host_data_i(hdata),
        .ld_0_i(ld0), .ld_1_i(ld1), .ld_2_i(ld2),
        .bus_o(bus), .clash_o(clash),
        .obs0_o(o0), .obs1_o(o1), .obs2_o(o2)
    );

    task automatic check(string req, logic [DW-1:0] got, logic [DW-1:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    function automatic logic [DW-1:0] exp_bus();
        if (drv0) return m_reg[0];
        if (drv1) return m_reg[1];
        if (drv2) return m_reg[2];
        if (hen)  return hdata;
        return m_keep;
    endfunction

    function automatic logic exp_clash();
        return (int'(drv0) + int'(drv1) + int'(drv2) + int'(hen)) > 1;
    endfunction

    // Called just after a negedge with inputs set: checks path, clocks, checks registers
    task automatic step(string tag);
        logic [DW-1:0] eb;
        logic          any;
        #2;
        eb  = exp_bus();
        any = drv0 | drv1 | drv2 | hen;
        check({tag, " R1/R5/R6 bus"}, bus, eb);
        check({tag, " R6 clash"}, {7'd0, clash}, {7'd0, exp_clash()});
        @(posedge clk);
        if (ld0) m_reg[0] = eb;
        if (ld1) m_reg[1] = eb;
        if (ld2) m_reg[2] = eb;
        if (any) m_keep = eb;
        @(negedge clk);
        check({tag, " R2/R3/R8 obs0"}, o0, m_reg[0]);
        check({tag, " R2/R3/R8 obs1"}, o1, m_reg[1]);
        check({tag, " R2/R3/R8 obs2"}, o2, m_reg[2]);
    endtask

    task automatic set(logic [3:0] en, logic [2:0] ld, logic [DW-1:0] d);
        {hen, drv2, drv1, drv0} = en;
        {ld2, ld1, ld0} = ld;
        hdata = d;
    endtask

    task automatic do_reset();
        set(4'b0, 3'b0, '0);
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        m_reg[0] = '0; m_reg[1] = '0; m_reg[2] = '0; m_keep = '0;
        #2;
        check("R4 obs0 after reset", o0, '0);
        check("R4 obs1 after reset", o1, '0);
        check("R4 obs2 after reset", o2, '0);
        check("R4 idle bus after reset", bus, '0);
    endtask

    initial begin
        #3_000_000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        r = $urandom(32'h0000_5eed);
        rst = 1'b1;
        set(4'b0, 3'b0, '0);
        @(negedge clk);
        do_reset();

        // Directed: host broadcast into all three registers (R2)
        @(negedge clk);
        set(4'b1000, 3'b111, 8'hA5); step("bcast");
        // Directed: host fills r1 and r2 with distinct values
        set(4'b1000, 3'b010, 8'h3C); step("fill1");
        set(4'b1000, 3'b100, 8'hC3); step("fill2");
        // Directed: move r1 into r0 (R1)
        set(4'b0010, 3'b001, 8'h00); step("r1_to_r0");
        // Directed: r2 drives and loads itself (R7)
        set(4'b0100, 3'b100, 8'hFF); step("r7_self");
        // Directed: contention r1 vs r2 vs host, r1 wins (R6)
        set(4'b1110, 3'b001, 8'h77); step("r6_clash");
        // Directed: idle path, load from keeper (R5)
        set(4'b0000, 3'b110, 8'h99); step("r5_idle_load");
        set(4'b0000, 3'b000, 8'h11); step("r5_idle_hold");

        for (int i = 0; i < 400; i++) begin
            logic [3:0] en;
            case ($urandom % 4)
                0: en = 4'b0000;
                1: en = 4'b0001 << ($urandom % 4);
                2: en = 4'($urandom);
                default: en = 4'b1000;
            endcase
            set(en, 3'($urandom), DW'($urandom));
            step("rand");
        end

        // Directed: reset mid-run clears registers and keeper (R4)
        do_reset();
        @(negedge clk);
        set(4'b0000, 3'b111, 8'h5A); step("r4_post_reset_idle");

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule